// File: doc/BRIEF.md
# I2C Master Bit Timing Unit

This block turns a stream of single-bit requests from an I2C master's sequencer into correctly timed bus activity. Each request drives SCL low. After a programmable hold interval the block moves SDA. It then keeps SCL low long enough to satisfy both the programmed low time and the programmed data setup time. When it releases SCL, it counts the high time only once the filtered SCL line has actually gone high, so a slave that stretches the clock simply delays the bit. At the end of the high time it samples the filtered SDA line and emits a one-cycle strobe.

All intervals are counted in core clocks. Typical settings are a 50/50 split of the bus period at 100 kHz with 250 ns setup, and a one-third high, two-thirds low split at 400 kHz with 100 ns setup. Both rates use 300 ns of hold after SCL falls and reject spikes shorter than 50 ns. Both incoming lines pass through a spike filter of programmable length. Outputs are open-drain enables, where 1 means pull the line low. START, STOP, address and byte sequencing belong to the block above.

Top module: `i2c_bit_timing`

## Requirements
- R1: After reset, both drive-low outputs are 0, the strobe and busy are 0, and both filtered lines read 1.
- R2: A filtered line takes a new level only after its raw input has shown that level at cfg_filter+1 consecutive clock edges. A shorter pulse leaves it unchanged.
- R3: A run request while idle raises scl_drive_low and busy in the next cycle and latches tx_bit.
- R4: sda_drive_low becomes the inverse of the latched bit exactly max(cfg_hold,1) cycles after scl_drive_low rises. sda_drive_low never changes unless scl_drive_low was 1 both in that cycle and in the one before.
- R5: scl_drive_low stays 1 for max(cfg_scl_low, h+cfg_setup, h+1) cycles, where h = max(cfg_hold,1).
- R6: The high count starts only once filtered SCL reads 1. bit_strobe rises 2+cfg_filter+max(cfg_scl_high,1) cycles after the SCL line actually goes high, whether it goes high on release or at the end of a slave's stretch (cfg_filter shorter than the low phase).
- R7: bit_strobe lasts exactly one cycle. rx_bit, valid with it, is the filtered SDA level at the end of the high count.
- R8: If run is high when the strobe is issued, scl_drive_low rises in that same cycle for the next bit. Otherwise the block goes idle with SCL released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_scl_high | input | CW | SCL high count in clocks (0 treated as 1) |
| cfg_scl_low | input | CW | SCL low count in clocks |
| cfg_setup | input | CW | Minimum clocks from SDA change to SCL release |
| cfg_hold | input | CW | Clocks from SCL fall to SDA change (0 treated as 1) |
| cfg_filter | input | FW | Spike filter length in clocks |
| run | input | 1 | Request the next bit |
| tx_bit | input | 1 | Bit to place on SDA |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| scl_drive_low | output | 1 | Open-drain enable for SCL |
| sda_drive_low | output | 1 | Open-drain enable for SDA |
| scl_clean | output | 1 | Filtered SCL |
| sda_clean | output | 1 | Filtered SDA |
| bit_strobe | output | 1 | One-cycle end-of-bit pulse |
| rx_bit | output | 1 | Sampled SDA, valid with bit_strobe |
| busy | output | 1 | A bit is in progress |

## Verification
The bench walks settings where the plain low count dominates the low phase, settings where setup dominates, and settings where hold dominates. A design that added instead of taking the maximum, or that ignored one term, would release SCL at the wrong cycle. A stretched bit checks that the high count waits for the line; a design counting from its own release would strobe while SCL is still held low. Spike pulses one cycle shorter and one cycle equal to the filter threshold expose an off-by-one in the filter. A slave pulling SDA low during a released bit exposes sampling of the driven value rather than the line. A held run request exposes a lost cycle between back-to-back bits.

// File: rtl/i2c_bt_pkg.sv
package i2c_bt_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LOW_HOLD,
        PH_LOW_REST,
        PH_HIGH_WAIT,
        PH_HIGH_CNT
    } phase_e;

    // Zero counts are stretched to a single clock.
    function automatic int unsigned at_least_one(int unsigned v);
        return (v == 0) ? 1 : v;
    endfunction

    // Clocks SCL stays low after SDA has moved: the low phase must cover
    // the plain low count and hold+setup, and last one clock past the hold.
    function automatic int unsigned rest_cycles(int unsigned low_len,
                                                int unsigned hold_eff,
                                                int unsigned setup_len);
        int unsigned total;
        int unsigned rest;
        total = low_len;
        if (hold_eff + setup_len > total) total = hold_eff + setup_len;
        rest  = (total > hold_eff) ? total - hold_eff : 0;
        return at_least_one(rest);
    endfunction

endpackage

// File: rtl/bt_glitch_filter.sv
module bt_glitch_filter #(
    parameter int FW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [FW-1:0] flt_len,
    input  logic          raw,
    output logic          clean
);
    logic [FW-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            clean   <= 1'b1;
            run_len <= '0;
        end else if (raw == clean) begin
            run_len <= '0;
        end else if (run_len >= flt_len) begin
            clean   <= raw;
            run_len <= '0;
        end else begin
            run_len <= run_len + 1'b1;
        end
    end

    // R2: a change of the filtered level always adopts the sampled raw level
    a_r2_flip_follows_raw: assert property (@(posedge clk) disable iff (rst)
        !$stable(clean) |-> (clean == $past(raw)));

endmodule

// File: rtl/bt_phase_ctrl.sv
module bt_phase_ctrl #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] high_len,
    input  logic [CW-1:0] hold_len,
    input  logic [CW-1:0] rest_len,
    input  logic          run,
    input  logic          tx_bit,
    input  logic          scl_f,
    input  logic          sda_f,
    output logic          scl_oe,
    output logic          sda_oe,
    output logic          strobe,
    output logic          rx_bit,
    output logic          busy
);
    import i2c_bt_pkg::*;

    phase_e        ph;
    logic [CW-1:0] cnt;
    logic          bit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= PH_IDLE;
            cnt    <= '0;
            scl_oe <= 1'b0;
            sda_oe <= 1'b0;
            strobe <= 1'b0;
            rx_bit <= 1'b0;
            bit_q  <= 1'b0;
        end else begin
            strobe <= 1'b0;
            case (ph)
                PH_IDLE: begin
                    if (run) begin
                        ph     <= PH_LOW_HOLD;
                        cnt    <= CW'(1);
                        scl_oe <= 1'b1;
                        bit_q  <= tx_bit;
                    end
                end
                PH_LOW_HOLD: begin
                    if (cnt >= hold_len) begin
                        sda_oe <= ~bit_q;
                        ph     <= PH_LOW_REST;
                        cnt    <= CW'(1);
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_LOW_REST: begin
                    if (cnt >= rest_len) begin
                        scl_oe <= 1'b0;
                        ph     <= PH_HIGH_WAIT;
                        cnt    <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_HIGH_WAIT: begin
                    if (scl_f) begin
                        ph  <= PH_HIGH_CNT;
                        cnt <= CW'(1);
                    end
                end
                PH_HIGH_CNT: begin
                    if (cnt >= high_len) begin
                        strobe <= 1'b1;
                        rx_bit <= sda_f;
                        if (run) begin
                            ph     <= PH_LOW_HOLD;
                            cnt    <= CW'(1);
                            scl_oe <= 1'b1;
                            bit_q  <= tx_bit;
                        end else begin
                            ph  <= PH_IDLE;
                            cnt <= '0;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign busy = (ph != PH_IDLE);

    // R3: a request in idle pulls SCL low on the next cycle
    a_r3_run_pulls_low: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_IDLE && run) |=> scl_oe);

    // R4: SDA only moves inside a low phase
    a_r4_sda_moves_in_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> (scl_oe && $past(scl_oe)));

    // R6: the end of the high phase is reached only with SCL seen high
    a_r6_strobe_after_high: assert property (@(posedge clk) disable iff (rst)
        $rose(strobe) |-> $past(scl_f));

    // R7: the strobe is a single-cycle pulse
    a_r7_strobe_single: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe);

endmodule

// File: rtl/i2c_bit_timing.sv
module i2c_bit_timing #(
    parameter int CW = 12,
    parameter int FW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cfg_scl_high,
    input  logic [CW-1:0] cfg_scl_low,
    input  logic [CW-1:0] cfg_setup,
    input  logic [CW-1:0] cfg_hold,
    input  logic [FW-1:0] cfg_filter,
    input  logic          run,
    input  logic          tx_bit,
    input  logic          scl_in,
    input  logic          sda_in,
    output logic          scl_drive_low,
    output logic          sda_drive_low,
    output logic          scl_clean,
    output logic          sda_clean,
    output logic          bit_strobe,
    output logic          rx_bit,
    output logic          busy
);
    import i2c_bt_pkg::*;

    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_vec;
    logic [NLINES-1:0] clean_vec;
    logic [CW-1:0]     high_eff;
    logic [CW-1:0]     hold_eff;
    logic [CW-1:0]     rest_len;

    assign raw_vec = {sda_in, scl_in};

    for (genvar i = 0; i < NLINES; i++) begin : g_flt
        bt_glitch_filter #(.FW(FW)) i_flt (
            .clk     (clk),
            .rst     (rst),
            .flt_len (cfg_filter),
            .raw     (raw_vec[i]),
            .clean   (clean_vec[i])
        );
    end

    assign scl_clean = clean_vec[0];
    assign sda_clean = clean_vec[1];

    assign high_eff = CW'(at_least_one(32'(cfg_scl_high)));
    assign hold_eff = CW'(at_least_one(32'(cfg_hold)));
    assign rest_len = CW'(rest_cycles(32'(cfg_scl_low), 32'(hold_eff), 32'(cfg_setup)));

    bt_phase_ctrl #(.CW(CW)) i_ctrl (
        .clk      (clk),
        .rst      (rst),
        .high_len (high_eff),
        .hold_len (hold_eff),
        .rest_len (rest_len),
        .run      (run),
        .tx_bit   (tx_bit),
        .scl_f    (scl_clean),
        .sda_f    (sda_clean),
        .scl_oe   (scl_drive_low),
        .sda_oe   (sda_drive_low),
        .strobe   (bit_strobe),
        .rx_bit   (rx_bit),
        .busy     (busy)
    );

endmodule

// File: tb/test_i2c_bit_timing.sv
module test_i2c_bit_timing;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 12;
    localparam int FW = 6;
    localparam int NVEC = 6;
    // columns: high, low, setup, hold, filter, bit, slave pulls SDA low
    localparam int unsigned VEC [NVEC][7] = '{
        '{5, 5, 1, 1, 0, 0, 0},
        '{3, 8, 2, 3, 1, 1, 0},
        '{4, 4, 5, 2, 2, 0, 0},
        '{1, 2, 0, 0, 0, 1, 0},
        '{6, 3, 0, 5, 1, 0, 0},
        '{2, 6, 1, 2, 0, 1, 1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [CW-1:0] cfg_scl_high = '0, cfg_scl_low = '0, cfg_setup = '0, cfg_hold = '0;
    logic [FW-1:0] cfg_filter = '0;
    logic run = 1'b0, tx_bit = 1'b0;
    logic stretch = 1'b0, slave_low = 1'b0, glitch = 1'b0;
    logic scl_drive_low, sda_drive_low, scl_clean, sda_clean, bit_strobe, rx_bit, busy;
    logic scl_in, sda_in;
    int n_checks = 0, n_fail = 0;
    bit finished = 0;

    assign scl_in = !scl_drive_low && !stretch;
    assign sda_in = !sda_drive_low && !slave_low && !glitch;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_bit_timing #(.CW(CW), .FW(FW)) i_i2c_bit_timing (
        .clk(clk), .rst(rst),
        .cfg_scl_high(cfg_scl_high), .cfg_scl_low(cfg_scl_low),
        .cfg_setup(cfg_setup), .cfg_hold(cfg_hold), .cfg_filter(cfg_filter),
        .run(run), .tx_bit(tx_bit), .scl_in(scl_in), .sda_in(sda_in),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
        .scl_clean(scl_clean), .sda_clean(sda_clean),
        .bit_strobe(bit_strobe), .rx_bit(rx_bit), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int max3(int a, int b, int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

    task automatic run_bit(input int hi, input int lo, input int su, input int ho,
                           input int fl, input bit b, input bit sl, input int s_cyc,
                           input bit keep_run);
        int h, hi_e, exp_l, exp_s, sda_k, rel_k, str_k;
        bit sda_start, rx_seen, oe_at;
        h     = (ho == 0) ? 1 : ho;
        hi_e  = (hi == 0) ? 1 : hi;
        exp_l = max3(lo, h + su, h + 1);
        exp_s = exp_l + s_cyc + 2 + fl + hi_e;
        @(negedge clk);
        cfg_scl_high = CW'(hi); cfg_scl_low = CW'(lo); cfg_setup = CW'(su);
        cfg_hold = CW'(ho); cfg_filter = FW'(fl);
        tx_bit = b; slave_low = sl; stretch = (s_cyc > 0); run = 1'b1;
        @(negedge clk);
        check(scl_drive_low == 1'b1, "R3 scl low after run", int'(scl_drive_low), 1);
        check(busy == 1'b1, "R3 busy after run", int'(busy), 1);
        if (!keep_run) run = 1'b0;
        sda_start = sda_drive_low;
        sda_k = -1; rel_k = -1; str_k = -1; rx_seen = 1'b0; oe_at = 1'b0;
        for (int k = 1; k < 400; k++) begin
            @(negedge clk);
            if (sda_k < 0 && sda_drive_low != sda_start) sda_k = k;
            if (rel_k < 0 && !scl_drive_low) rel_k = k;
            if (s_cyc > 0 && k == exp_l + s_cyc) stretch = 1'b0;
            if (bit_strobe) begin
                str_k = k; rx_seen = rx_bit; oe_at = scl_drive_low;
                break;
            end
        end
        if (sda_start != !b)
            check(sda_k == h, "R4 sda change cycle", sda_k, h);
        check(sda_drive_low == !b, "R4 sda level", int'(sda_drive_low), int'(!b));
        check(rel_k == exp_l, "R5 low phase length", rel_k, exp_l);
        check(str_k == exp_s, "R6 strobe cycle", str_k, exp_s);
        check(rx_seen == (b && !sl), "R7 sampled bit", int'(rx_seen), int'(b && !sl));
        if (keep_run) begin
            check(oe_at == 1'b1, "R8 next low starts at strobe", int'(oe_at), 1);
            run = 1'b0;
        end
        @(negedge clk);
        check(bit_strobe == 1'b0, "R7 strobe width", int'(bit_strobe), 0);
        if (!keep_run) begin
            check(scl_drive_low == 1'b0 && busy == 1'b0, "R8 idle after bit",
                  int'({scl_drive_low, busy}), 0);
        end else begin
            for (int k = 0; k < 400 && busy; k++) @(negedge clk);
        end
    endtask

    task automatic glitch_sda(input int fl, input int n, input int exp_k);
        int first_k;
        @(negedge clk);
        cfg_filter = FW'(fl);
        repeat (fl + 3) @(negedge clk);
        glitch = 1'b1;
        first_k = -1;
        for (int k = 1; k <= n + fl + 3; k++) begin
            @(negedge clk);
            if (k == n) glitch = 1'b0;
            if (first_k < 0 && !sda_clean) first_k = k;
        end
        check(first_k == exp_k, "R2 filter response cycle", first_k, exp_k);
        check(sda_clean == 1'b1, "R2 filter settles high", int'(sda_clean), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle state after reset
        check(scl_drive_low == 0 && sda_drive_low == 0, "R1 drives released",
              int'({scl_drive_low, sda_drive_low}), 0);
        check(bit_strobe == 0 && busy == 0, "R1 strobe and busy",
              int'({bit_strobe, busy}), 0);
        check(scl_clean == 1 && sda_clean == 1, "R1 filtered lines",
              int'({scl_clean, sda_clean}), 3);

        for (int v = 0; v < NVEC; v++)
            run_bit(int'(VEC[v][0]), int'(VEC[v][1]), int'(VEC[v][2]), int'(VEC[v][3]),
                    int'(VEC[v][4]), VEC[v][5] != 0, VEC[v][6] != 0, 0, 1'b0);

        // R6: slave stretches SCL for 5 clocks
        run_bit(3, 4, 1, 1, 1, 1'b0, 1'b0, 5, 1'b0);
        // R8: back-to-back bits with run held
        run_bit(2, 3, 1, 1, 0, 1'b1, 1'b0, 0, 1'b1);

        // R2: pulse shorter than threshold dropped, equal length passes
        glitch_sda(3, 3, -1);
        glitch_sda(3, 4, 4);
        glitch_sda(0, 1, 1);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule